// File: doc/BRIEF.md
# Partitionable Program SRAM/Cache Memory

This block is a 32 KB level-1 instruction-side memory. One physical array is shared between directly addressed SRAM and a direct-mapped, read-only cache. A 3-bit partition setting, written through a small configuration port, sets how much of the array belongs to each. The cache always takes the top of the local region, and the SRAM window runs from the region base up to the cache boundary. Fetches that hit the SRAM window or the cache return their 32-bit word in the same cycle.

The local region starts at byte address 0x00E00000 and is 0x8000 bytes long. A fetch that falls inside the SRAM window reads the array directly. Any other fetch, whether inside the region above the boundary or outside it, goes through the cache. On a miss the block issues one line-fill request to the next memory level and takes eight 32-bit beats in address order. It then installs the 32-byte line and returns the requested word. Because both partitions share one array, data left by an earlier fill stays readable as SRAM after the partition changes.

Top module: `l1p_partmem`

## Requirements
- R1: After reset the partition code is 4 (all cache, no SRAM window), so the first fetch to 0x00E00000 misses and raises `fillReq`. With no fetch pending, `fetchReady` and `fillReq` are low.
- R2: Partition codes give these cache sizes: 0 → none, 1 → 4 KB, 2 → 8 KB, 3 → 16 KB, 4 → 32 KB. SRAM spans 0x00E00000 up to 0x00E08000 minus the cache size. A fetch in that window has `fetchReady` high in the same cycle and returns word (addr[4:2]) of array line (addr − base)[14:5].
- R3: The cache with C lines occupies array lines 1024−C to 1023. A cached line address L (addr[31:5]) uses array line (1024−C) + (L mod C). After a change to code 0, that line's data is readable as SRAM at base + 32·line.
- R4: A cache miss raises `fillReq` for exactly one cycle with `fillAddr` = the fetch address with bits [4:0] cleared. The block accepts 8 `fillValid` beats, each carrying the word at byte offset 4·n. In the cycle after the last beat it raises `fetchReady` with the requested word.
- R5: A fetch whose line is valid in the cache with a matching tag completes in the same cycle with no fill request.
- R6: Two line addresses that share an index in the current cache size evict each other, and each re-fetch after eviction misses again.
- R7: A configuration write of a legal code that differs from the current one invalidates every cache line. In that cycle `fetchReady` and `fillReq` stay low.
- R8: Writing codes 5 to 7, or rewriting the current code, changes neither the partition nor the cache contents.
- R9: With code 0, every fetch outside the SRAM window is fetched from the next level on each access, and nothing is kept.
- R10: SRAM window fetches never raise `fillReq` and leave cache lines untouched. A line cached before an SRAM read still hits afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, held until `fetchReady` |
| fetchAddr | input | 32 | Fetch byte address |
| fetchReady | output | 1 | Fetch complete this cycle |
| fetchData | output | 32 | Fetched word |
| cfgWe | input | 1 | Partition code write strobe |
| cfgMode | input | 3 | Partition code to write |
| fillReq | output | 1 | One-cycle line-fill request |
| fillAddr | output | 32 | Line-aligned fill byte address |
| fillValid | input | 1 | Fill beat valid |
| fillData | input | 32 | Fill beat data |

## Verification
The bench first fills every array line in the all-cache setting, then reads the whole SRAM window in the no-cache setting. A design that placed the cache at the bottom of the region, or mixed up the slot offset, would return words from the wrong line. It probes each boundary from both sides: the last SRAM word must not fill, and the first cache word must fill. An off-by-one boundary would either skip a fill or trigger a needless one. It forces index conflicts in every cache size, which a design with a fixed index width would get wrong. It also checks that reserved or repeated code writes keep lines hitting, and that real changes stall the fetch and clear the tags. A design that invalidated on any write, or failed to invalidate, would turn expected hits into misses or leave stale lines hitting.

// File: rtl/l1p_pkg.sv
package l1p_pkg;
  localparam int ADDR_W         = 32;
  localparam int WORD_W         = 32;
  localparam int LINE_BYTES     = 32;
  localparam int REGION_BYTES   = 32768;
  localparam int MODE_W         = 3;
  localparam int WORDS_PER_LINE = LINE_BYTES / (WORD_W / 8);
  localparam int TOTAL_LINES    = REGION_BYTES / LINE_BYTES;
  localparam int LINE_IDX_W     = $clog2(TOTAL_LINES);
  localparam int OFF_W          = $clog2(LINE_BYTES);
  localparam int WSEL_W         = $clog2(WORDS_PER_LINE);
  localparam int LADDR_W        = ADDR_W - OFF_W;
  localparam int REGION_W       = $clog2(REGION_BYTES);
  localparam int LINE_W         = WORD_W * WORDS_PER_LINE;
  localparam logic [ADDR_W-1:0] REGION_BASE = 32'h00E0_0000;
  localparam logic [MODE_W-1:0] MODE_MAX    = 3'd4;

  // Control-to-datapath strobe bundle
  typedef struct packed {
    logic                  invalidateAll;
    logic                  captureBeat;
    logic [WSEL_W-1:0]     beatIdx;
    logic                  installLine;
    logic [LINE_IDX_W-1:0] installIdx;
    logic [LADDR_W-1:0]    installTag;
    logic [LINE_IDX_W-1:0] readIdx;
    logic [WSEL_W-1:0]     readWord;
    logic                  selectBuf;
  } dpCtrl_t;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    return m <= MODE_MAX;
  endfunction

  // Number of cache lines for a partition code (0 for none or reserved)
  function automatic logic [LINE_IDX_W:0] cacheLinesOf(input logic [MODE_W-1:0] m);
    logic [LINE_IDX_W:0] full;
    full = (LINE_IDX_W+1)'(TOTAL_LINES);
    if (m == '0 || m > MODE_MAX) return '0;
    return full >> (MODE_MAX - m);
  endfunction
endpackage

// File: rtl/l1p_ctrl.sv
module l1p_ctrl
  import l1p_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = REGION_BASE
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                fetchReq,
  input  logic [ADDR_W-1:0]   fetchAddr,
  output logic                fetchReady,
  input  logic                cfgWe,
  input  logic [MODE_W-1:0]   cfgMode,
  output logic                fillReq,
  output logic [ADDR_W-1:0]   fillAddr,
  input  logic                fillValid,
  input  logic [LADDR_W-1:0]  rdTag,
  input  logic                rdValid,
  output dpCtrl_t             ctl,
  output logic [MODE_W-1:0]   curMode
);
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DONE} state_t;

  state_t                state;
  logic [MODE_W-1:0]     modeReg;
  logic [WSEL_W-1:0]     beatCnt;
  logic [WSEL_W-1:0]     reqWord;
  logic [LINE_IDX_W-1:0] fillLine;
  logic [LADDR_W-1:0]    fillTag;
  logic                  installOk;

  logic [LADDR_W-1:0]    lineAddr;
  logic [LINE_IDX_W-1:0] regLine;
  logic [LINE_IDX_W:0]   cacheLines;
  logic [LINE_IDX_W:0]   sramLines;
  logic [LINE_IDX_W-1:0] cacheMask;
  logic [LINE_IDX_W-1:0] cacheSlot;
  logic                  inRegion;
  logic                  isSram;
  logic                  hasCache;
  logic                  modeChange;
  logic                  hit;
  logic                  startFill;

  assign curMode    = modeReg;
  assign lineAddr   = fetchAddr[ADDR_W-1:OFF_W];
  assign regLine    = fetchAddr[REGION_W-1:OFF_W];
  assign inRegion   = fetchAddr[ADDR_W-1:REGION_W] == BASE_ADDR[ADDR_W-1:REGION_W];
  assign cacheLines = cacheLinesOf(modeReg);
  assign sramLines  = (LINE_IDX_W+1)'(TOTAL_LINES) - cacheLines;
  assign cacheMask  = cacheLines[LINE_IDX_W-1:0] - 1'b1;
  assign cacheSlot  = (lineAddr[LINE_IDX_W-1:0] & cacheMask) + sramLines[LINE_IDX_W-1:0];
  assign isSram     = inRegion && ({1'b0, regLine} < sramLines);
  assign hasCache   = modeReg != '0;
  assign modeChange = cfgWe && modeLegal(cfgMode) && (cfgMode != modeReg);
  assign hit        = hasCache && rdValid && (rdTag == lineAddr);
  assign startFill  = (state == ST_IDLE) && fetchReq && !modeChange && !isSram && !hit;
  assign fillAddr   = {lineAddr, {OFF_W{1'b0}}};

  always_comb begin
    fetchReady        = 1'b0;
    fillReq           = 1'b0;
    ctl               = '0;
    ctl.invalidateAll = modeChange;
    ctl.beatIdx       = beatCnt;
    ctl.installIdx    = fillLine;
    ctl.installTag    = fillTag;
    ctl.readIdx       = isSram ? regLine : cacheSlot;
    ctl.readWord      = fetchAddr[OFF_W-1:OFF_W-WSEL_W];
    unique case (state)
      ST_IDLE: begin
        fetchReady = fetchReq && !modeChange && (isSram || hit);
        fillReq    = startFill;
      end
      ST_FILL: ctl.captureBeat = fillValid;
      ST_DONE: begin
        ctl.selectBuf   = 1'b1;
        ctl.readWord    = reqWord;
        fetchReady      = !modeChange;
        ctl.installLine = installOk && !modeChange;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      modeReg   <= MODE_MAX;
      beatCnt   <= '0;
      reqWord   <= '0;
      fillLine  <= '0;
      fillTag   <= '0;
      installOk <= 1'b0;
    end else begin
      if (modeChange) modeReg <= cfgMode;
      unique case (state)
        ST_IDLE: if (startFill) begin
          state     <= ST_FILL;
          beatCnt   <= '0;
          reqWord   <= fetchAddr[OFF_W-1:OFF_W-WSEL_W];
          fillLine  <= cacheSlot;
          fillTag   <= lineAddr;
          installOk <= hasCache;
        end
        ST_FILL: begin
          if (modeChange) installOk <= 1'b0;
          if (fillValid) begin
            beatCnt <= beatCnt + 1'b1;
            if (beatCnt == WSEL_W'(WORDS_PER_LINE - 1)) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (modeChange) installOk <= 1'b0;
          else            state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l1p_datapath.sv
module l1p_datapath
  import l1p_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctl,
  input  logic [WORD_W-1:0]  fillData,
  output logic [WORD_W-1:0]  rdData,
  output logic [LADDR_W-1:0] rdTag,
  output logic               rdValid
);
  logic [LINE_W-1:0]      lineMem [TOTAL_LINES];
  logic [LADDR_W-1:0]     tagMem  [TOTAL_LINES];
  logic [TOTAL_LINES-1:0] validVec;
  logic [WORD_W-1:0]      lineBuf [WORDS_PER_LINE];
  logic [LINE_W-1:0]      bufPacked;
  logic [LINE_W-1:0]      rdLine;
  logic [WORD_W-1:0]      lineWords [WORDS_PER_LINE];

  assign rdLine = lineMem[ctl.readIdx];

  for (genvar g = 0; g < WORDS_PER_LINE; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (ctl.captureBeat && ctl.beatIdx == WSEL_W'(g)) lineBuf[g] <= fillData;
    end
    assign bufPacked[g*WORD_W +: WORD_W] = lineBuf[g];
    assign lineWords[g]                  = rdLine[g*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (ctl.installLine) begin
      lineMem[ctl.installIdx] <= bufPacked;
      tagMem[ctl.installIdx]  <= ctl.installTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.invalidateAll) validVec <= '0;
    else if (ctl.installLine)        validVec[ctl.installIdx] <= 1'b1;
  end

  assign rdData  = ctl.selectBuf ? lineBuf[ctl.readWord] : lineWords[ctl.readWord];
  assign rdTag   = tagMem[ctl.readIdx];
  assign rdValid = validVec[ctl.readIdx];
endmodule

// File: rtl/l1p_partmem.sv
module l1p_partmem
  import l1p_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = REGION_BASE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [WORD_W-1:0] fetchData,
  input  logic              cfgWe,
  input  logic [MODE_W-1:0] cfgMode,
  output logic              fillReq,
  output logic [ADDR_W-1:0] fillAddr,
  input  logic              fillValid,
  input  logic [WORD_W-1:0] fillData
);
  dpCtrl_t            ctl;
  logic [LADDR_W-1:0] rdTag;
  logic               rdValid;
  logic [MODE_W-1:0]  curMode;

  l1p_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .cfgWe(cfgWe), .cfgMode(cfgMode),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillValid(fillValid),
    .rdTag(rdTag), .rdValid(rdValid), .ctl(ctl), .curMode(curMode)
  );

  l1p_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fillData(fillData),
    .rdData(fetchData), .rdTag(rdTag), .rdValid(rdValid)
  );
endmodule

// File: rtl/l1p_partmem_checker.sv
module l1p_partmem_checker
  import l1p_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR = REGION_BASE
) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchReady,
  input logic              cfgWe,
  input logic [MODE_W-1:0] cfgMode,
  input logic              fillReq,
  input logic [ADDR_W-1:0] fillAddr,
  input logic [MODE_W-1:0] curMode
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] sramBytes;
  logic              inSram;
  logic              stallCond;
  logic              busy;

  always_comb begin
    case (curMode)
      3'd0:    sramBytes = 32'd32768;
      3'd1:    sramBytes = 32'd28672;
      3'd2:    sramBytes = 32'd24576;
      3'd3:    sramBytes = 32'd16384;
      default: sramBytes = 32'd0;
    endcase
  end
  assign offs      = fetchAddr - BASE_ADDR;
  assign inSram    = (fetchAddr >= BASE_ADDR) && (offs < sramBytes);
  assign stallCond = cfgWe && (cfgMode <= 3'd4) && (cfgMode != curMode);

  always_ff @(posedge clk) begin
    if (!rstN)           busy <= 1'b0;
    else if (fillReq)    busy <= 1'b1;
    else if (fetchReady) busy <= 1'b0;
  end

  p_sram_zero_wait_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && inSram && !stallCond && !busy |-> fetchReady);
  p_fill_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |-> (fillAddr[OFF_W-1:0] == '0) && (fillAddr[ADDR_W-1:OFF_W] == fetchAddr[ADDR_W-1:OFF_W]));
  p_fill_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    fillReq |=> !fillReq);
  p_change_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    stallCond |-> !fetchReady && !fillReq);
  p_reserved_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && (cfgMode > 3'd4) |=> $stable(curMode));
  p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    curMode <= 3'd4);
  p_sram_no_fill_r10: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && inSram |-> !fillReq);
endmodule

bind l1p_partmem l1p_partmem_checker #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
  .fetchReady(fetchReady), .cfgWe(cfgWe), .cfgMode(cfgMode),
  .fillReq(fillReq), .fillAddr(fillAddr), .curMode(curMode)
);

// File: tb/l1p_partmem_bench.sv
module l1p_partmem_bench;
  localparam int CLK_NS = 20;
  localparam logic [31:0] BASE = 32'h00E0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgMode = '0;
  logic        fillReq;
  logic [31:0] fillAddr;
  logic        fillValid = 1'b0;
  logic [31:0] fillData = '0;

  l1p_partmem u_l1p_partmem (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .cfgWe(cfgWe),
    .cfgMode(cfgMode), .fillReq(fillReq), .fillAddr(fillAddr),
    .fillValid(fillValid), .fillData(fillData)
  );

  always #(CLK_NS/2) clk = ~clk;

  int          nCmp = 0;
  int          nBad = 0;
  int          curM = 4;
  bit          vModel [1024];
  logic [31:0] tModel [1024];
  logic [31:0] srcModel [1024];
  bit          srcKnown [1024];

  function automatic logic [31:0] nextWord(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h3C5A_0F00;
  endfunction

  function automatic int cacheBytesOf(input int m);
    return (m == 0) ? 0 : (4096 << (m - 1));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fetch(input logic [31:0] a, input string tag);
    int          cb;
    int          sramB;
    int          n;
    int          p;
    logic [31:0] offs;
    logic [31:0] la;
    logic [31:0] wa;
    bit          inSram;
    bit          hit;
    cb     = cacheBytesOf(curM);
    sramB  = 32768 - cb;
    offs   = a - BASE;
    la     = a >> 5;
    wa     = a & 32'hFFFF_FFFC;
    inSram = (a >= BASE) && (offs < 32'(sramB));
    @(negedge clk);
    fetchReq  = 1'b1;
    fetchAddr = a;
    #1;
    if (inSram) begin
      p = int'(offs >> 5);
      chk(fetchReady === 1'b1 && fillReq === 1'b0, {tag, " sram ready/nofill"}, {fetchReady, fillReq}, 32'd2);
      if (srcKnown[p])
        chk(fetchData === nextWord({srcModel[p][26:0], 5'b0} + (a & 32'h1C)), {tag, " sram data"},
            fetchData, nextWord({srcModel[p][26:0], 5'b0} + (a & 32'h1C)));
    end else begin
      n   = cb / 32;
      p   = (sramB / 32) + ((n > 0) ? int'(la % 32'(n)) : 0);
      hit = (cb > 0) && vModel[p] && (tModel[p] == la);
      if (hit) begin
        chk(fetchReady === 1'b1 && fillReq === 1'b0, {tag, " hit ready"}, {fetchReady, fillReq}, 32'd2);
        chk(fetchData === nextWord(wa), {tag, " hit data"}, fetchData, nextWord(wa));
      end else begin
        chk(fillReq === 1'b1 && fetchReady === 1'b0, {tag, " miss fillReq"}, {fetchReady, fillReq}, 32'd1);
        if (fillReq === 1'b1) begin
          chk(fillAddr === {la[26:0], 5'b0}, {tag, " fillAddr"}, fillAddr, {la[26:0], 5'b0});
          for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            fillValid = 1'b1;
            fillData  = nextWord({la[26:0], 5'b0} + 32'(b * 4));
          end
          @(negedge clk);
          fillValid = 1'b0;
          #1;
          chk(fetchReady === 1'b1, {tag, " fill return ready"}, {31'b0, fetchReady}, 32'd1);
          chk(fetchData === nextWord(wa), {tag, " fill return data"}, fetchData, nextWord(wa));
          if (cb > 0) begin
            vModel[p]   = 1'b1;
            tModel[p]   = la;
            srcModel[p] = la;
            srcKnown[p] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic setMode(input int m, input string tag);
    bit chg;
    chg = (m <= 4) && (m != curM);
    @(negedge clk);
    cfgWe     = 1'b1;
    cfgMode   = 3'(m);
    fetchReq  = chg;
    fetchAddr = BASE + 32'h40;
    #1;
    if (chg) chk(fetchReady === 1'b0 && fillReq === 1'b0, {tag, " stall on change"}, {fetchReady, fillReq}, 32'd0);
    @(negedge clk);
    cfgWe    = 1'b0;
    fetchReq = 1'b0;
    if (chg) begin
      curM = m;
      foreach (vModel[i]) vModel[i] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++;
    nBad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    logic [31:0] ca;
    logic [31:0] cbAddr;
    foreach (vModel[i]) begin
      vModel[i] = 1'b0; tModel[i] = '0; srcModel[i] = '0; srcKnown[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(fetchReady === 1'b0 && fillReq === 1'b0, "R1 idle after reset", {fetchReady, fillReq}, 32'd0);

    // R1: all-cache after reset, R5: hits
    fetch(BASE, "R1 first fetch misses");
    fetch(BASE + 4, "R5 same line hit");
    fetch(BASE + 28, "R5 last word hit");
    // R4: fill every array line in all-cache mode
    for (int i = 0; i < 1024; i++) fetch(BASE + 32'(i * 32 + (i % 8) * 4), "R4 fill sweep");
    for (int i = 0; i < 1024; i += 37) fetch(BASE + 32'(i * 32 + 8), "R5 hit sweep");
    // R6: conflict in 32 KB cache
    fetch(BASE + 32'h8000, "R6 conflict in all-cache");
    fetch(BASE, "R6 evicted line misses");

    // R7 + R2: whole SRAM sweep
    setMode(0, "R7 to mode 0");
    for (int w = 0; w < 8192; w++) fetch(BASE + 32'(w * 4), "R2 sram sweep mode 0");
    // R9: no cache retention
    fetch(32'h2000_0000, "R9 uncached 1");
    fetch(32'h2000_0000, "R9 uncached 2");
    fetch(BASE + 32'h8000, "R9 above region uncached");

    // mode 3: 16 KB cache
    setMode(3, "R7 to mode 3");
    fetch(BASE + 32'h3FFC, "R2 boundary last sram mode 3");
    fetch(BASE + 32'h4000, "R2 boundary first cache mode 3");
    ca     = 32'h1000_0000;
    cbAddr = ca + 32'(512 * 32);
    fetch(ca, "R6 A miss");
    fetch(ca + 4, "R6 A hit");
    fetch(cbAddr, "R6 B conflict miss");
    fetch(ca, "R6 A re-miss");
    fetch(BASE + 32'h100, "R10 sram read between");
    fetch(ca + 8, "R10 cached line still hits");
    for (int w = 0; w < 1024; w++) fetch(BASE + 32'(w * 16), "R2 sram sweep mode 3");
    // R8: reserved and same-code writes
    setMode(5, "R8 reserved 5");
    setMode(7, "R8 reserved 7");
    setMode(3, "R8 same code");
    fetch(ca + 12, "R8 line survives writes");
    fetch(BASE + 32'h3FF8, "R8 boundary unchanged sram");
    fetch(BASE + 32'h4004, "R8 boundary unchanged cache");

    // R3: mode 1 slot mapping seen through SRAM in mode 0
    setMode(1, "R7 to mode 1");
    fetch(ca + 12, "R7 invalidated line misses");
    fetch(BASE + 32'h6FFC, "R2 boundary last sram mode 1");
    fetch(BASE + 32'h7000, "R2 boundary first cache mode 1");
    for (int k = 0; k < 128; k++) fetch(32'h3000_0000 + 32'(k * 32 + 4), "R3 fill mode 1");
    fetch(32'h3000_0000 + 32'(128 * 32), "R6 conflict mode 1");
    setMode(0, "R7 back to mode 0");
    for (int w = 896 * 8; w < 8192; w++) fetch(BASE + 32'(w * 4), "R3 slot mapping via sram");

    // mode 2: 8 KB cache
    setMode(2, "R7 to mode 2");
    fetch(BASE + 32'h5FFC, "R2 boundary last sram mode 2");
    fetch(BASE + 32'h6000, "R2 boundary first cache mode 2");
    for (int k = 0; k < 64; k++) begin
      fetch(32'h4000_0000 + 32'(k * 32), "R6 fill mode 2");
      fetch(32'h4000_0000 + 32'(k * 32 + 256 * 32), "R6 conflict mode 2");
      fetch(32'h4000_0000 + 32'(k * 32 + 4), "R6 re-miss mode 2");
    end
    setMode(0, "R7 to mode 0 again");
    for (int w = 768 * 8; w < 8192; w += 3) fetch(BASE + 32'(w * 4), "R3 mode 2 mapping via sram");

    @(negedge clk);
    fetchReq = 1'b0;
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule